// File: doc/BRIEF.md
# Key Derivation Sequencing Controller

This block is the control engine of a hierarchical key-derivation unit. It holds the current working state and takes one command at a time from software: step forward through the derivation chain, produce an identity value, produce a software output value, or shut down. Before it starts a command it checks that the command is allowed in the current state, that the requested key version does not exceed the permitted maximum, and that none of the hardware inputs holds a degenerate pattern. A command that passes these checks goes to an external hash engine through a request/valid/error handshake. A command that fails them completes at once with an error.

Every command ends with a one-cycle done pulse and a success or fail status. Failures also raise a recoverable alert and an error interrupt, and they set bits in a sticky error-cause mask. A lifecycle enable input can shut the unit off: this wipes the working key and locks the chain. A fault input, or a corrupted state register, forces a terminal invalid state and holds a fatal alert.

Top module: `kdf_ctrl`

## Requirements
- R1: `state_o` reports the working state as 0 Reset, 1 CreatorRoot, 2 OwnerIntermediate, 3 OwnerRoot, 4 Disabled, 5 Invalid. An advance command (`cmd_op_i`=0) in states 0 to 2 uses the hash engine. On success it moves to the next state and loads the digest into `work_key_o` with `work_key_vld_o`=1. An advance in state 3 goes straight to 4 with no hash request, wiping the key.
- R2: Generate-identity (`cmd_op_i`=1) and generate-output (`cmd_op_i`=2) are legal only in states 1 to 3. A command that is illegal in the current state fails, sets error bit 0, and pulses `err_irq_o` and `recov_alert_o`.
- R3: Each accepted command ends with a single-cycle `op_done_o`, and `op_status_o` becomes 2 (success) or 3 (fail). `op_status_o` is 1 while the hash engine is awaited and 0 after reset.
- R4: A generate command with `key_ver_i` greater than `max_ver_i` fails with error bit 1. It bit-inverts `work_key_o` and leaves the state unchanged. A command with `key_ver_i` equal to `max_ver_i` is accepted.
- R5: A hash-using command fails with error bit 2 and issues no hash request when any of the five hardware inputs (root key, health, ROM digest, creator seed, owner seed) is all zeros or all ones, or when `root_key_vld_i` or `rom_dig_vld_i` is low. State and `sw_out_o` stay unchanged.
- R6: When `hash_valid_i` arrives, an error flag or an all-zeros or all-ones digest fails the command with error bit 3. Otherwise a generate command loads the digest into `sw_out_o` with `sw_out_vld_o`=1.
- R7: `err_code_o` is sticky. A bit of `err_clr_i` clears the matching bit.
- R8: `bind_wen_o` is 1 after reset and is cleared by every successful advance. `bind_rearm_i` sets it again.
- R9: While `hash_req_o` is high, `cfg_wen_o` is 0 and both `cmd_start_i` and `bind_rearm_i` are ignored.
- R10: `lc_en_i` low in states 1 to 3 forces state 4, wipes the key and clears `sw_out_vld_o`, so later generates fail. With `lc_en_i` low in Reset, advance fails with error bit 0. It works again once `lc_en_i` returns.
- R11: `fault_i` high, or a state register code outside the legal set, sets `fault_sts_o` and `fatal_alert_o` for good and forces state 5. Every later command fails with error bit 0.
- R12: A disable command (`cmd_op_i`=3) in any state other than 5 succeeds at once, enters state 4 and wipes the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lc_en_i | input | 1 | Lifecycle enable |
| fault_i | input | 1 | Fatal fault from integrity checks |
| cmd_start_i | input | 1 | Command start strobe |
| cmd_op_i | input | 2 | Command: 0 advance, 1 gen identity, 2 gen output, 3 disable |
| key_ver_i | input | VER_W | Requested key version |
| max_ver_i | input | VER_W | Maximum version for the current state |
| root_key_i | input | KEY_W | Root key |
| root_key_vld_i | input | 1 | Root key valid |
| health_i | input | KEY_W | Lifecycle health word |
| rom_dig_i | input | KEY_W | ROM digest |
| rom_dig_vld_i | input | 1 | ROM digest valid |
| creator_seed_i | input | KEY_W | Creator seed |
| owner_seed_i | input | KEY_W | Owner seed |
| err_clr_i | input | 4 | Write-one-to-clear for error bits |
| bind_rearm_i | input | 1 | Re-enable binding writes |
| hash_valid_i | input | 1 | Hash engine result valid |
| hash_err_i | input | 1 | Hash engine error |
| hash_digest_i | input | KEY_W | Hash engine digest |
| hash_req_o | output | 1 | Hash request, held until valid |
| work_key_o | output | KEY_W | Working key toward the hash engine |
| work_key_vld_o | output | 1 | Working key valid |
| sw_out_o | output | KEY_W | Software output value |
| sw_out_vld_o | output | 1 | Software output valid |
| state_o | output | 3 | Working state index |
| op_status_o | output | 2 | 0 idle, 1 busy, 2 success, 3 fail |
| op_done_o | output | 1 | Command completion pulse |
| err_irq_o | output | 1 | Error interrupt pulse |
| recov_alert_o | output | 1 | Recoverable alert pulse |
| fatal_alert_o | output | 1 | Fatal alert, held |
| err_code_o | output | 4 | Sticky error causes: bit0 command, bit1 version, bit2 input data, bit3 hash |
| fault_sts_o | output | 1 | Sticky fault status |
| cfg_wen_o | output | 1 | Configuration write enable |
| bind_wen_o | output | 1 | Binding write enable |

## Verification
Results of the immediate path (illegal command, version and data failures, disable, final advance) are visible one cycle after the edge that samples `cmd_start_i`. Hash-based results are visible one cycle after the edge that samples `hash_valid_i`, and lifecycle or fault effects one cycle after the edge that samples them. The bench drives inputs on the falling edge. Its reference model updates on the rising edge from the same sampled inputs, and every output is compared on the next falling edge, so each result is checked exactly in the cycle it is due. Directed checks are taken only after a command task has seen `hash_req_o` low again, which is the cycle that carries the done pulse.

// File: rtl/kdf_ctrl_pkg.sv
package kdf_ctrl_pkg;

   typedef enum logic [1:0] {
      OP_ADVANCE = 2'd0,
      OP_GEN_ID  = 2'd1,
      OP_GEN_SW  = 2'd2,
      OP_DISABLE = 2'd3
   } kdf_op_e;

   typedef enum logic [2:0] {
      WS_RESET     = 3'd0,
      WS_CREATOR   = 3'd1,
      WS_OWNER_INT = 3'd2,
      WS_OWNER     = 3'd3,
      WS_DISABLED  = 3'd4,
      WS_INVALID   = 3'd5
   } kdf_ws_e;

   typedef enum logic [1:0] {
      STS_IDLE = 2'd0,
      STS_BUSY = 2'd1,
      STS_OK   = 2'd2,
      STS_FAIL = 2'd3
   } kdf_sts_e;

   localparam int unsigned ERR_W    = 4;
   localparam int unsigned ERR_CMD  = 0;
   localparam int unsigned ERR_VER  = 1;
   localparam int unsigned ERR_DATA = 2;
   localparam int unsigned ERR_HASH = 3;

   // sparse state codes, pairwise distance of at least four
   localparam int unsigned ENC_W = 8;
   localparam logic [ENC_W-1:0] ENC_RESET     = 8'b0101_1100;
   localparam logic [ENC_W-1:0] ENC_CREATOR   = 8'b1010_0110;
   localparam logic [ENC_W-1:0] ENC_OWNER_INT = 8'b0011_1001;
   localparam logic [ENC_W-1:0] ENC_OWNER     = 8'b1100_0011;
   localparam logic [ENC_W-1:0] ENC_DISABLED  = 8'b1111_0000;
   localparam logic [ENC_W-1:0] ENC_INVALID   = 8'b0000_1111;

   function automatic logic [ENC_W-1:0] ws_encode(kdf_ws_e s);
      case (s)
         WS_RESET:     return ENC_RESET;
         WS_CREATOR:   return ENC_CREATOR;
         WS_OWNER_INT: return ENC_OWNER_INT;
         WS_OWNER:     return ENC_OWNER;
         WS_DISABLED:  return ENC_DISABLED;
         default:      return ENC_INVALID;
      endcase
   endfunction

   function automatic logic ws_operating(kdf_ws_e s);
      return (s == WS_CREATOR) || (s == WS_OWNER_INT) || (s == WS_OWNER);
   endfunction

   function automatic logic op_legal(kdf_op_e op, kdf_ws_e s, logic lc_en);
      if (s == WS_INVALID) return 1'b0;
      case (op)
         OP_DISABLE: return 1'b1;
         OP_ADVANCE: return (s != WS_DISABLED) && !(s == WS_RESET && !lc_en);
         default:    return ws_operating(s);
      endcase
   endfunction

   function automatic kdf_ws_e ws_next(kdf_ws_e s);
      case (s)
         WS_RESET:     return WS_CREATOR;
         WS_CREATOR:   return WS_OWNER_INT;
         WS_OWNER_INT: return WS_OWNER;
         default:      return WS_DISABLED;
      endcase
   endfunction

endpackage

// File: rtl/kdf_pattern_check.sv
module kdf_pattern_check #(
   parameter int unsigned NUM_VAL = 1,
   parameter int unsigned VAL_W   = 32
) (
   input  logic [NUM_VAL-1:0][VAL_W-1:0] vals_i,
   output logic                          bad_o
);
   logic [NUM_VAL-1:0] bad_each;

   for (genvar g = 0; g < NUM_VAL; g++) begin : g_val
      assign bad_each[g] = (&vals_i[g]) | ~(|vals_i[g]);
   end

   assign bad_o = |bad_each;
endmodule

// File: rtl/kdf_state_reg.sv
module kdf_state_reg
   import kdf_ctrl_pkg::*;
(
   input  logic    clk_i,
   input  logic    rst_ni,
   input  kdf_ws_e ws_d_i,
   output kdf_ws_e ws_q_o,
   output logic    illegal_o
);
   logic [ENC_W-1:0] code_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) code_q <= ENC_RESET;
      else         code_q <= ws_encode(ws_d_i);
   end

   always_comb begin
      illegal_o = 1'b0;
      case (code_q)
         ENC_RESET:     ws_q_o = WS_RESET;
         ENC_CREATOR:   ws_q_o = WS_CREATOR;
         ENC_OWNER_INT: ws_q_o = WS_OWNER_INT;
         ENC_OWNER:     ws_q_o = WS_OWNER;
         ENC_DISABLED:  ws_q_o = WS_DISABLED;
         ENC_INVALID:   ws_q_o = WS_INVALID;
         default: begin
            ws_q_o    = WS_INVALID;
            illegal_o = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/kdf_ctrl.sv
module kdf_ctrl
   import kdf_ctrl_pkg::*;
#(
   parameter int unsigned KEY_W = 32,
   parameter int unsigned VER_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             lc_en_i,
   input  logic             fault_i,
   input  logic             cmd_start_i,
   input  logic [1:0]       cmd_op_i,
   input  logic [VER_W-1:0] key_ver_i,
   input  logic [VER_W-1:0] max_ver_i,
   input  logic [KEY_W-1:0] root_key_i,
   input  logic             root_key_vld_i,
   input  logic [KEY_W-1:0] health_i,
   input  logic [KEY_W-1:0] rom_dig_i,
   input  logic             rom_dig_vld_i,
   input  logic [KEY_W-1:0] creator_seed_i,
   input  logic [KEY_W-1:0] owner_seed_i,
   input  logic [ERR_W-1:0] err_clr_i,
   input  logic             bind_rearm_i,
   input  logic             hash_valid_i,
   input  logic             hash_err_i,
   input  logic [KEY_W-1:0] hash_digest_i,
   output logic             hash_req_o,
   output logic [KEY_W-1:0] work_key_o,
   output logic             work_key_vld_o,
   output logic [KEY_W-1:0] sw_out_o,
   output logic             sw_out_vld_o,
   output logic [2:0]       state_o,
   output logic [1:0]       op_status_o,
   output logic             op_done_o,
   output logic             err_irq_o,
   output logic             recov_alert_o,
   output logic             fatal_alert_o,
   output logic [ERR_W-1:0] err_code_o,
   output logic             fault_sts_o,
   output logic             cfg_wen_o,
   output logic             bind_wen_o
);
   localparam int unsigned NUM_HW = 5;

   if (KEY_W < 4) begin : g_bad_key_w
      $error("kdf_ctrl: KEY_W must be at least 4");
   end
   if (VER_W < 1) begin : g_bad_ver_w
      $error("kdf_ctrl: VER_W must be at least 1");
   end

   kdf_ws_e ws_q, ws_d;
   logic    ws_illegal;

   kdf_state_reg u_state (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ws_d_i    (ws_d),
      .ws_q_o    (ws_q),
      .illegal_o (ws_illegal)
   );

   logic [NUM_HW-1:0][KEY_W-1:0] hw_vals;
   logic                         hw_pat_bad, dig_pat_bad;
   assign hw_vals = {root_key_i, health_i, rom_dig_i, creator_seed_i, owner_seed_i};

   kdf_pattern_check #(.NUM_VAL(NUM_HW), .VAL_W(KEY_W)) u_hw_chk (
      .vals_i (hw_vals),
      .bad_o  (hw_pat_bad)
   );
   kdf_pattern_check #(.NUM_VAL(1), .VAL_W(KEY_W)) u_dig_chk (
      .vals_i (hash_digest_i),
      .bad_o  (dig_pat_bad)
   );

   logic             busy_q, busy_d, kv_q, kv_d, swv_q, swv_d;
   logic             done_q, done_d, fail_q, fail_d, fs_q, fs_d, bind_q, bind_d;
   kdf_op_e          op_q, op_d, op_in;
   kdf_sts_e         sts_q, sts_d;
   logic [KEY_W-1:0] key_q, key_d, sw_q, sw_d;
   logic [ERR_W-1:0] err_q, err_d, err_new;
   logic             ok, fail, ver_bad, dat_bad;

   assign op_in = kdf_op_e'(cmd_op_i);

   always_comb begin
      ws_d    = ws_q;
      busy_d  = busy_q;
      op_d    = op_q;
      key_d   = key_q;
      kv_d    = kv_q;
      sw_d    = sw_q;
      swv_d   = swv_q;
      bind_d  = bind_q;
      sts_d   = sts_q;
      fs_d    = fs_q;
      err_new = '0;
      ok      = 1'b0;
      fail    = 1'b0;
      ver_bad = (op_in != OP_ADVANCE) && (key_ver_i > max_ver_i);
      dat_bad = hw_pat_bad || !root_key_vld_i || !rom_dig_vld_i;

      if (bind_rearm_i && !busy_q) bind_d = 1'b1;

      if (busy_q) begin
         if (hash_valid_i) begin
            busy_d = 1'b0;
            if (!op_legal(op_q, ws_q, lc_en_i)) begin
               fail             = 1'b1;
               err_new[ERR_CMD] = 1'b1;
            end else if (hash_err_i || dig_pat_bad) begin
               fail              = 1'b1;
               err_new[ERR_HASH] = 1'b1;
            end else begin
               ok = 1'b1;
               if (op_q == OP_ADVANCE) begin
                  key_d  = hash_digest_i;
                  kv_d   = 1'b1;
                  ws_d   = ws_next(ws_q);
                  bind_d = 1'b0;
               end else begin
                  sw_d  = hash_digest_i;
                  swv_d = 1'b1;
               end
            end
         end
      end else if (cmd_start_i) begin
         op_d = op_in;
         if (fs_q || !op_legal(op_in, ws_q, lc_en_i)) begin
            fail             = 1'b1;
            err_new[ERR_CMD] = 1'b1;
         end else if (op_in == OP_DISABLE || (op_in == OP_ADVANCE && ws_q == WS_OWNER)) begin
            ok    = 1'b1;
            ws_d  = WS_DISABLED;
            key_d = '0;
            kv_d  = 1'b0;
            swv_d = 1'b0;
            if (op_in == OP_ADVANCE) bind_d = 1'b0;
         end else if (ver_bad || dat_bad) begin
            fail              = 1'b1;
            err_new[ERR_VER]  = ver_bad;
            err_new[ERR_DATA] = dat_bad;
            if (ver_bad) key_d = ~key_q;
         end else begin
            busy_d = 1'b1;
            sts_d  = STS_BUSY;
         end
      end

      if (fail)    sts_d = STS_FAIL;
      else if (ok) sts_d = STS_OK;
      done_d = ok | fail;
      fail_d = fail;
      err_d  = (err_q & ~err_clr_i) | err_new;

      if (!lc_en_i && ws_operating(ws_q)) begin
         ws_d  = WS_DISABLED;
         key_d = '0;
         kv_d  = 1'b0;
         swv_d = 1'b0;
      end

      if (fault_i || ws_illegal) fs_d = 1'b1;
      if (fault_i || ws_illegal || fs_q) begin
         ws_d  = WS_INVALID;
         key_d = '0;
         kv_d  = 1'b0;
         swv_d = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         op_q   <= OP_ADVANCE;
         key_q  <= '0;
         kv_q   <= 1'b0;
         sw_q   <= '0;
         swv_q  <= 1'b0;
         bind_q <= 1'b1;
         sts_q  <= STS_IDLE;
         done_q <= 1'b0;
         fail_q <= 1'b0;
         err_q  <= '0;
         fs_q   <= 1'b0;
      end else begin
         busy_q <= busy_d;
         op_q   <= op_d;
         key_q  <= key_d;
         kv_q   <= kv_d;
         sw_q   <= sw_d;
         swv_q  <= swv_d;
         bind_q <= bind_d;
         sts_q  <= sts_d;
         done_q <= done_d;
         fail_q <= fail_d;
         err_q  <= err_d;
         fs_q   <= fs_d;
      end
   end

   assign hash_req_o     = busy_q;
   assign cfg_wen_o      = ~busy_q;
   assign work_key_o     = key_q;
   assign work_key_vld_o = kv_q;
   assign sw_out_o       = sw_q;
   assign sw_out_vld_o   = swv_q;
   assign state_o        = ws_q;
   assign op_status_o    = sts_q;
   assign op_done_o      = done_q;
   assign err_irq_o      = fail_q;
   assign recov_alert_o  = fail_q;
   assign fatal_alert_o  = fs_q;
   assign err_code_o     = err_q;
   assign fault_sts_o    = fs_q;
   assign bind_wen_o     = bind_q;
endmodule

// File: rtl/kdf_ctrl_chk.sv
module kdf_ctrl_chk #(
   parameter int unsigned KEY_W = 32
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             lc_en_i,
   input logic             fault_i,
   input logic             hash_req_o,
   input logic             cfg_wen_o,
   input logic [KEY_W-1:0] work_key_o,
   input logic             work_key_vld_o,
   input logic [2:0]       state_o,
   input logic [1:0]       op_status_o,
   input logic             op_done_o,
   input logic             err_irq_o,
   input logic             recov_alert_o,
   input logic             fatal_alert_o,
   input logic             fault_sts_o
);
   a_r1_state_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(state_o) |-> (state_o == $past(state_o) + 3'd1) || (state_o >= 3'd4));

   a_r2_irq_with_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_irq_o |-> (op_status_o == 2'd3) && recov_alert_o && op_done_o);

   a_r3_done_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
      op_done_o |-> (op_status_o == 2'd2) || (op_status_o == 2'd3));

   a_r9_no_cfg_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hash_req_o |-> !cfg_wen_o);

   a_r10_lc_wipe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lc_en_i && state_o >= 3'd1 && state_o <= 3'd3) |=> (!work_key_vld_o && work_key_o == '0));

   a_r11_fault_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_i |=> (state_o == 3'd5) && fault_sts_o && fatal_alert_o);

   a_r11_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_sts_o |=> fault_sts_o);
endmodule

bind kdf_ctrl kdf_ctrl_chk #(.KEY_W(KEY_W)) u_kdf_ctrl_chk (.*);

// File: tb/test_kdf_ctrl.sv
module test_kdf_ctrl;
   logic clk = 1'b0, rst_n = 1'b0;
   logic lc_en, fault, cmd_start, root_vld, rom_vld, rearm, hash_valid, hash_err;
   logic [1:0]  cmd_op;
   logic [7:0]  key_ver, max_ver;
   logic [31:0] root_key, health, rom_dig, c_seed, o_seed, hd;
   logic [3:0]  err_clr;
   logic        hash_req, kv, swv, done, irq, ralert, fatal, fsts, cfg_wen, bind_wen;
   logic [31:0] wkey, sw;
   logic [2:0]  st;
   logic [1:0]  sts;
   logic [3:0]  err;
   int checks = 0, fails = 0, hlat = 0, hcnt = 0;

   always #10 clk = ~clk;

   kdf_ctrl i_kdf_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .lc_en_i(lc_en), .fault_i(fault),
      .cmd_start_i(cmd_start), .cmd_op_i(cmd_op), .key_ver_i(key_ver), .max_ver_i(max_ver),
      .root_key_i(root_key), .root_key_vld_i(root_vld), .health_i(health),
      .rom_dig_i(rom_dig), .rom_dig_vld_i(rom_vld), .creator_seed_i(c_seed),
      .owner_seed_i(o_seed), .err_clr_i(err_clr), .bind_rearm_i(rearm),
      .hash_valid_i(hash_valid), .hash_err_i(hash_err), .hash_digest_i(hd),
      .hash_req_o(hash_req), .work_key_o(wkey), .work_key_vld_o(kv), .sw_out_o(sw),
      .sw_out_vld_o(swv), .state_o(st), .op_status_o(sts), .op_done_o(done),
      .err_irq_o(irq), .recov_alert_o(ralert), .fatal_alert_o(fatal), .err_code_o(err),
      .fault_sts_o(fsts), .cfg_wen_o(cfg_wen), .bind_wen_o(bind_wen));

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // hash engine: answers a request after hlat further cycles
   always @(negedge clk) begin
      if (!rst_n) begin hash_valid = 1'b0; hcnt = 0; end
      else if (hash_valid) begin hash_valid = 1'b0; hcnt = 0; end
      else if (hash_req) begin
         if (hcnt >= hlat) hash_valid = 1'b1;
         else hcnt++;
      end
   end

   // behavioural reference model
   int m_st, m_op, m_sts, m_err;
   logic m_busy, m_kv, m_swv, m_done, m_irq, m_fs, m_bind;
   logic [31:0] m_key, m_sw;

   function automatic bit pat(input logic [31:0] v);
      return (v == 32'h0) || (v == 32'hFFFF_FFFF);
   endfunction

   function automatic bit legal(input int op, input int s, input logic lc);
      if (s == 5) return 0;
      if (op == 3) return 1;
      if (op == 0) return (s <= 3) && !(s == 0 && !lc);
      return (s >= 1) && (s <= 3);
   endfunction

   always @(posedge clk) begin
      bit f, ok, vb, db;
      int nb;
      if (!rst_n) begin
         m_st = 0; m_op = 0; m_sts = 0; m_err = 0; m_busy = 0; m_kv = 0; m_swv = 0;
         m_done = 0; m_irq = 0; m_fs = 0; m_bind = 1; m_key = 0; m_sw = 0;
      end else begin
         f = 0; ok = 0; nb = 0;
         if (rearm && !m_busy) m_bind = 1;
         if (m_busy) begin
            if (hash_valid) begin
               m_busy = 0;
               if (!legal(m_op, m_st, lc_en)) begin f = 1; nb = 1; end
               else if (hash_err || pat(hd)) begin f = 1; nb = 8; end
               else begin
                  ok = 1;
                  if (m_op == 0) begin m_key = hd; m_kv = 1; m_st++; m_bind = 0; end
                  else begin m_sw = hd; m_swv = 1; end
               end
            end
         end else if (cmd_start) begin
            m_op = cmd_op;
            vb = (m_op != 0) && (key_ver > max_ver);
            db = pat(root_key) || pat(health) || pat(rom_dig) || pat(c_seed) || pat(o_seed)
                 || !root_vld || !rom_vld;
            if (m_fs || !legal(m_op, m_st, lc_en)) begin f = 1; nb = 1; end
            else if (m_op == 3 || (m_op == 0 && m_st == 3)) begin
               ok = 1; m_st = 4; m_key = 0; m_kv = 0; m_swv = 0;
               if (m_op == 0) m_bind = 0;
            end else if (vb || db) begin
               f = 1; nb = (vb ? 2 : 0) | (db ? 4 : 0);
               if (vb) m_key = ~m_key;
            end else begin m_busy = 1; m_sts = 1; end
         end
         if (f) m_sts = 3; else if (ok) m_sts = 2;
         m_done = f | ok;
         m_irq  = f;
         m_err  = (m_err & ~int'(err_clr)) | nb;
         if (!lc_en && m_st >= 1 && m_st <= 3) begin m_st = 4; m_key = 0; m_kv = 0; m_swv = 0; end
         if (fault) m_fs = 1;
         if (m_fs) begin m_st = 5; m_key = 0; m_kv = 0; m_swv = 0; end
      end
   end

   // full comparison on every falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         cmp("R1 state", st, m_st);
         cmp("R1 work key", wkey, m_key);
         cmp("R1 work key valid", kv, m_kv);
         cmp("R6 sw out", sw, m_sw);
         cmp("R6 sw out valid", swv, m_swv);
         cmp("R3 status", sts, m_sts);
         cmp("R3 done", done, m_done);
         cmp("R2 err irq", irq, m_irq);
         cmp("R2 recov alert", ralert, m_irq);
         cmp("R7 err code", err, m_err);
         cmp("R9 hash req", hash_req, m_busy);
         cmp("R9 cfg wen", cfg_wen, !m_busy);
         cmp("R8 bind wen", bind_wen, m_bind);
         cmp("R11 fault status", fsts, m_fs);
         cmp("R11 fatal alert", fatal, m_fs);
      end
   end

   task automatic run(input int op);
      @(negedge clk); cmd_op = op[1:0]; cmd_start = 1'b1;
      @(negedge clk); cmd_start = 1'b0;
      while (hash_req) @(negedge clk);
   endtask

   task automatic clear(input logic [3:0] m);
      @(negedge clk); err_clr = m;
      @(negedge clk); err_clr = 4'h0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      lc_en = 1; fault = 0; cmd_start = 0; cmd_op = 0; key_ver = 8'd5; max_ver = 8'd5;
      root_key = 32'h1234_5678; health = 32'h0F0F_1234; rom_dig = 32'hCAFE_0001;
      c_seed = 32'h1111_2222; o_seed = 32'h3333_4444; root_vld = 1; rom_vld = 1;
      err_clr = 0; rearm = 0; hash_err = 0; hd = 32'hA5A5_0001; hash_valid = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cmp("R1 reset state", st, 0);
      cmp("R3 reset status", sts, 0);
      cmp("R8 reset bind", bind_wen, 1);

      run(2);
      cmp("R2 gen in Reset rejected", err[0], 1);
      cmp("R2 alert pulse", ralert, 1);
      clear(4'h1);
      cmp("R7 bit cleared", err, 0);

      run(0);
      cmp("R1 advance to CreatorRoot", st, 1);
      cmp("R1 key is digest", wkey, 32'hA5A5_0001);
      cmp("R8 cleared by advance", bind_wen, 0);

      hd = 32'h5A5A_0002; run(2);
      cmp("R4 equal version accepted", sts, 2);
      cmp("R6 sw out is digest", sw, 32'h5A5A_0002);

      key_ver = 8'd6; run(1);
      cmp("R4 greater version rejected", err[1], 1);
      cmp("R4 key inverted", wkey, ~32'hA5A5_0001);
      cmp("R4 state kept", st, 1);
      key_ver = 8'd5;

      root_key = 32'h0; run(2);
      cmp("R5 zero root key", err[2], 1);
      cmp("R5 sw out kept", sw, 32'h5A5A_0002);
      root_key = 32'h1234_5678; o_seed = 32'hFFFF_FFFF; run(1);
      cmp("R5 all-ones seed", sts, 3);
      o_seed = 32'h3333_4444; rom_vld = 0; run(0);
      cmp("R5 digest flag low", st, 1);
      rom_vld = 1;
      clear(4'hF);
      cmp("R7 all cleared", err, 0);

      hash_err = 1; run(2);
      cmp("R6 hash error", err[3], 1);
      hash_err = 0; hd = 32'hFFFF_FFFF; run(2);
      cmp("R6 all-ones digest", sts, 3);
      hd = 32'h0BAD_F00D;

      hlat = 6;
      @(negedge clk); cmd_op = 2'd2; cmd_start = 1;
      @(negedge clk); cmd_start = 0;
      repeat (2) @(negedge clk);
      cmp("R9 cfg wen low while busy", cfg_wen, 0);
      cmd_op = 2'd0; cmd_start = 1; rearm = 1;
      @(negedge clk); cmd_start = 0; rearm = 0;
      while (hash_req) @(negedge clk);
      cmp("R9 start ignored", st, 1);
      cmp("R9 rearm ignored", bind_wen, 0);
      hlat = 1;
      @(negedge clk); rearm = 1;
      @(negedge clk); rearm = 0;
      cmp("R8 rearm", bind_wen, 1);

      hd = 32'h1357_9BDF; run(0);
      cmp("R1 OwnerIntermediate", st, 2);
      hd = 32'h2468_ACE0; run(0);
      cmp("R1 OwnerRoot", st, 3);
      run(0);
      cmp("R1 advance to Disabled", st, 4);
      cmp("R1 key wiped", kv, 0);
      run(1);
      cmp("R2 gen in Disabled rejected", sts, 3);

      do_reset();
      lc_en = 0; run(0);
      cmp("R10 blocked in Reset", st, 0);
      cmp("R10 blocked error", err[0], 1);
      lc_en = 1; hd = 32'hA5A5_0001; run(0);
      cmp("R10 after re-enable", st, 1);
      @(negedge clk); lc_en = 0;
      @(negedge clk);
      cmp("R10 forced Disabled", st, 4);
      cmp("R10 key wiped", wkey, 0);
      lc_en = 1; run(2);
      cmp("R10 later output invalid", swv, 0);

      do_reset();
      run(0);
      run(3);
      cmp("R12 disable command", st, 4);
      cmp("R12 disable succeeds", sts, 2);

      do_reset();
      run(0);
      @(negedge clk); fault = 1;
      @(negedge clk); fault = 0;
      cmp("R11 Invalid state", st, 5);
      cmp("R11 fatal alert", fatal, 1);
      run(2);
      cmp("R11 gen fails", sts, 3);
      run(3);
      cmp("R11 disable fails", st, 5);
      cmp("R11 command error", err[0], 1);

      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule